// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the device side of a receive ring of descriptors kept in shared memory. The ring holds 2^LOG_RING descriptors of 16 bytes each, placed one after another from `ring_base`. When a frame starts on the byte stream, the block fetches the current descriptor and checks its ownership bit. If the device owns it, the block writes the frame bytes into the descriptor's buffer and stops at the buffer's capacity. It then writes back the received length and a status half-word, which returns the descriptor to the host. The next frame uses the next descriptor.

If the host has not handed the descriptor over, the block consumes and discards the frame, raises a one-cycle missed pulse and keeps its ring position. Memory is reached through a 32-bit request/acknowledge port with byte strobes. A request is held steady until it is acknowledged, and read data is valid in the acknowledge cycle. The frame check result and the framing and FIFO error indications arrive as flags with the last byte. The byte count includes the frame check bytes, because they are part of the stream.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `mem_req`, `rx_ready` and `missed` are all low, and the block stays idle until `rx_valid` is seen.
- R2: Descriptor i lives at ring_base + 16*i. On a frame start the block first reads the control word at offset 4 (bits [15:0] buffer length, bits [31:16] status, bit 31 = device owns). If bit 31 is set, it then reads the buffer address word at offset 0.
- R3: If bit 31 of the control word is clear, every byte of the frame is accepted and discarded. `missed` pulses high for exactly one cycle and no memory write is issued. The same descriptor is used for the next frame.
- R4: Frame bytes go to the buffer in little-endian order (byte k at buffer address + k) through word writes whose strobes cover only the bytes received. `rx_ready` is never high while a memory request is pending.
- R5: The buffer capacity is the two's-complement negation of control word bits [15:0] (0xFFF0 means 16 bytes).
- R6: After the data, the word at offset 8 is written with full strobes. Bits [11:0] hold the number of bytes stored and the upper bits are zero. This write comes before the status write.
- R7: The last write of a frame goes to offset 4 with strobe 4'b1100, which leaves the length half unchanged. It writes bit 31 = 0, bits 25 and 24 = 1 (start and end of frame), bit 29 = framing error, bit 28 = overflow, bit 27 = frame check error (`rx_crc_ok` low), bit 26 = FIFO error, bit 30 = OR of the four error bits, and bits [23:16] = 0.
- R8: Bytes past the buffer capacity are not written. Overflow is flagged, the stored length equals the capacity, and the descriptor is still returned.
- R9: The ring index advances after each returned descriptor and wraps from 2^LOG_RING-1 to 0.
- R10: While `mem_req` is high and `mem_ack` is low, the request (address, write enable, data) does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Last byte of the frame |
| rx_crc_ok | input | 1 | Frame check passed, valid with rx_last |
| rx_frame_err | input | 1 | Framing error, valid with rx_last |
| rx_fifo_err | input | 1 | FIFO error, valid with rx_last |
| rx_ready | output | 1 | Byte accepted when high with rx_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte strobes for writes |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| missed | output | 1 | One-cycle pulse when a frame finds no owned descriptor |

## Verification
The bench targets the capacity edges. A frame that exactly fills the buffer must not be flagged as overflow. A frame that overruns it must leave the following byte untouched. A design with an off-by-one limit would corrupt memory next to the buffer or report the wrong length. Short frames that end in the middle of a word check the strobes, since a design that wrote the full word would clobber the neighbouring bytes. A frame sent while the host owns the descriptor must cause no write and no ring advance, so that the next frame lands in that same descriptor. The bench also checks the order of the two write-backs and the wrap to descriptor 0. A design that returned ownership first, or wrapped late, would give a wrong write log or send the frame to the wrong buffer.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW       = 32,
  parameter int LOG_RING = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_crc_ok,
  input  logic          rx_frame_err,
  input  logic          rx_fifo_err,
  output logic          rx_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_wstrb,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          missed
);

  localparam int SZW = 16;
  localparam int LNW = 12;

  typedef enum logic [2:0] {
    S_IDLE, S_RDCTL, S_RDBUF, S_DROP, S_RECV, S_WDAT, S_WLEN, S_WST
  } state_t;

  state_t              state;
  logic [LOG_RING-1:0] idx;
  logic [AW-1:0]       buf_addr, waddr, desc;
  logic [SZW-1:0]      cap, cnt;
  logic [31:0]         wword;
  logic [3:0]          wstrb_r;
  logic                f_last, f_ovf, f_crc, f_fram, f_fifo, miss_r;
  logic                acc, room;
  logic [15:0]         stat;

  assign desc = ring_base + (AW'(idx) << 4);
  assign acc  = rx_valid && rx_ready;
  assign room = (cnt != cap);
  assign stat = {1'b0, (f_fram | f_ovf | f_crc | f_fifo), f_fram, f_ovf, f_crc, f_fifo, 2'b11, 8'h00};

  assign rx_ready = (state == S_RECV) || (state == S_DROP);
  assign mem_req  = (state == S_RDCTL) || (state == S_RDBUF) || mem_we;
  assign mem_we   = (state == S_WDAT) || (state == S_WLEN) || (state == S_WST);
  assign missed   = miss_r;

  always_comb begin
    mem_addr  = desc;
    mem_wdata = 32'h0;
    mem_wstrb = 4'h0;
    case (state)
      S_RDCTL: mem_addr = desc + AW'(4);
      S_WDAT: begin
        mem_addr  = waddr;
        mem_wdata = wword;
        mem_wstrb = wstrb_r;
      end
      S_WLEN: begin
        mem_addr  = desc + AW'(8);
        mem_wdata = {{(32-LNW){1'b0}}, cnt[LNW-1:0]};
        mem_wstrb = 4'hF;
      end
      S_WST: begin
        mem_addr  = desc + AW'(4);
        mem_wdata = {stat, 16'h0};
        mem_wstrb = 4'hC;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      buf_addr <= '0;
      waddr    <= '0;
      cap      <= '0;
      cnt      <= '0;
      wword    <= '0;
      wstrb_r  <= '0;
      f_last   <= 1'b0;
      f_ovf    <= 1'b0;
      f_crc    <= 1'b0;
      f_fram   <= 1'b0;
      f_fifo   <= 1'b0;
      miss_r   <= 1'b0;
    end else begin
      miss_r <= 1'b0;
      case (state)
        S_IDLE: if (rx_valid) begin
          state   <= S_RDCTL;
          cnt     <= '0;
          wstrb_r <= '0;
          f_last  <= 1'b0;
          f_ovf   <= 1'b0;
          f_crc   <= 1'b0;
          f_fram  <= 1'b0;
          f_fifo  <= 1'b0;
        end
        S_RDCTL: if (mem_ack) begin
          cap <= ~mem_rdata[SZW-1:0] + SZW'(1);
          if (mem_rdata[31]) state <= S_RDBUF;
          else begin
            state  <= S_DROP;
            miss_r <= 1'b1;
          end
        end
        S_RDBUF: if (mem_ack) begin
          buf_addr <= {mem_rdata[AW-1:2], 2'b00};
          state    <= S_RECV;
        end
        S_DROP: if (acc && rx_last) state <= S_IDLE;
        S_RECV: if (acc) begin
          if (room) begin
            wword[8*cnt[1:0] +: 8] <= rx_data;
            wstrb_r[cnt[1:0]]      <= 1'b1;
            waddr                  <= buf_addr + AW'({cnt[SZW-1:2], 2'b00});
            cnt                    <= cnt + SZW'(1);
          end else begin
            f_ovf <= 1'b1;
          end
          if (rx_last) begin
            f_last <= 1'b1;
            f_crc  <= ~rx_crc_ok;
            f_fram <= rx_frame_err;
            f_fifo <= rx_fifo_err;
          end
          if ((room && (cnt[1:0] == 2'd3 || rx_last)) || (!room && rx_last && |wstrb_r))
            state <= S_WDAT;
          else if (rx_last)
            state <= S_WLEN;
        end
        S_WDAT: if (mem_ack) begin
          wstrb_r <= '0;
          state   <= f_last ? S_WLEN : S_RECV;
        end
        S_WLEN: if (mem_ack) state <= S_WST;
        S_WST: if (mem_ack) begin
          idx   <= idx + 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module rx_ring_writer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [3:0]    mem_wstrb,
  input logic          mem_ack,
  input logic          missed
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

  AST_MISS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    missed |=> !missed); // R3

  AST_STREAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !mem_req); // R4

  AST_WRITE_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wstrb != 4'h0); // R4

  AST_HANDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_wstrb == 4'hC |-> !mem_wdata[31] && mem_wdata[25:24] == 2'b11 && mem_wdata[23:16] == 8'h00); // R7

  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_wstrb == 4'hC |-> mem_wdata[30] == |mem_wdata[29:26]); // R7

endmodule

bind rx_ring_writer rx_ring_writer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_ack(mem_ack),
  .missed(missed)
);

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_crc_ok = 1'b1, rx_frame_err = 1'b0, rx_fifo_err = 1'b0;
  logic [7:0]  rx_data = 8'h0;
  logic        rx_ready, mem_req, mem_we, mem_ack, missed;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;

  always #10 clk = ~clk;

  rx_ring_writer #(.AW(32), .LOG_RING(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_crc_ok(rx_crc_ok), .rx_frame_err(rx_frame_err), .rx_fifo_err(rx_fifo_err),
    .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .missed(missed)
  );

  logic [31:0] mem [128];
  int wc = 0, opcnt = 0, hold_err = 0, wcount = 0, miss_cnt = 0;
  logic [31:0] paddr = 0, rl_prev = 0, rl_last = 0, wl_prev = 0, wl_last = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= 32'h0;
      wc <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wc == 0) paddr <= mem_addr;
        else if (mem_addr != paddr) hold_err <= hold_err + 1;
        if (wc >= opcnt % 3) begin
          wc <= 0;
          opcnt <= opcnt + 1;
          mem_ack <= 1'b1;
          if (mem_we) begin
            for (int b = 0; b < 4; b++)
              if (mem_wstrb[b]) mem[mem_addr[8:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            wl_prev <= wl_last;
            wl_last <= mem_addr;
            wcount <= wcount + 1;
          end else begin
            mem_rdata <= mem[mem_addr[8:2]];
            rl_prev <= rl_last;
            rl_last <= mem_addr;
          end
        end else wc <= wc + 1;
      end
    end
  end

  always @(posedge clk) if (rst_n && missed) miss_cnt <= miss_cnt + 1;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] getb(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  // len[19:12] size[11:4] crc_ok[3] frame_err[2] fifo_err[1] own[0]
  localparam logic [19:0] VEC [8] = '{
    {8'd5,  8'd16, 4'b1001},
    {8'd8,  8'd16, 4'b0001},
    {8'd16, 8'd16, 4'b1001},
    {8'd20, 8'd16, 4'b1001},
    {8'd1,  8'd16, 4'b1111},
    {8'd6,  8'd16, 4'b1000},
    {8'd7,  8'd16, 4'b1001},
    {8'd12, 8'd10, 4'b0001}
  };

  task automatic send(input int v, input int len, input bit crc_ok, input bit fe, input bit fi);
    for (int k = 0; k < len; k++) begin
      rx_valid = 1'b1;
      rx_data = 8'(v * 32 + k + 1);
      rx_last = (k == len - 1);
      rx_crc_ok = crc_ok;
      rx_frame_err = fe;
      rx_fifo_err = fi;
      @(negedge clk);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
      #1;
    end
    rx_valid = 1'b0;
    rx_last = 1'b0;
  endtask

  initial begin
    int eidx = 0;
    for (int i = 0; i < 128; i++) mem[i] = 32'hEEEEEEEE;
    repeat (3) @(negedge clk);
    chk(!mem_req && !rx_ready && !missed, "R1 outputs in reset", {29'b0, mem_req, rx_ready, missed}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && !rx_ready && !missed, "R1 idle after reset", {29'b0, mem_req, rx_ready, missed}, 32'h0);

    for (int v = 0; v < 8; v++) begin
      int len, size, d, bufa, stored, w0, m0;
      bit crc_ok, fe, fi, own, ovf;
      logic [15:0] hi;
      logic [31:0] ctl;
      len = int'(VEC[v][19:12]);
      size = int'(VEC[v][11:4]);
      crc_ok = VEC[v][3]; fe = VEC[v][2]; fi = VEC[v][1]; own = VEC[v][0];
      d = eidx * 16;
      bufa = 32'h80 + eidx * 32'h40;
      for (int i = 0; i < 16; i++) mem[(bufa >> 2) + i] = 32'hEEEEEEEE;
      ctl = {own, 15'b0, 16'(-size)};
      mem[d >> 2] = bufa;
      mem[(d >> 2) + 1] = ctl;
      mem[(d >> 2) + 2] = 32'h0;
      w0 = wcount; m0 = miss_cnt;
      send(v, len, crc_ok, fe, fi);
      repeat (40) @(negedge clk);
      if (!own) begin
        chk(miss_cnt == m0 + 1, "R3 missed pulse count", miss_cnt - m0, 1);
        chk(wcount == w0, "R3 no writes on drop", wcount - w0, 0);
        chk(mem[(d >> 2) + 1] == ctl, "R3 descriptor untouched", mem[(d >> 2) + 1], ctl);
      end else begin
        bit bad = 1'b0;
        logic [7:0] ab = 0, eb = 0;
        ovf = (len > size);
        stored = ovf ? size : len;
        hi = {1'b0, (fe | ovf | !crc_ok | fi), fe, ovf, !crc_ok, fi, 2'b11, 8'h00};
        chk(rl_prev == d + 4 && rl_last == d, "R2 read order ctl then buffer", rl_prev, d + 4);
        chk(mem[(d >> 2) + 1] == {hi, 16'(-size)}, "R7 R5 status word", mem[(d >> 2) + 1], {hi, 16'(-size)});
        chk(mem[(d >> 2) + 2] == stored, "R6 R8 length word", mem[(d >> 2) + 2], stored);
        chk(wl_prev == d + 8 && wl_last == d + 4, "R6 length before status", wl_prev, d + 8);
        for (int k = 0; k < stored; k++)
          if (!bad && getb(bufa + k) != 8'(v * 32 + k + 1)) begin
            bad = 1'b1; ab = getb(bufa + k); eb = 8'(v * 32 + k + 1);
          end
        chk(!bad, "R4 buffer bytes", ab, eb);
        chk(getb(bufa + stored) == 8'hEE, "R8 R4 byte past data untouched", getb(bufa + stored), 8'hEE);
        if (v == 4) chk(d == 0, "R9 wrap to descriptor 0", d, 0);
        eidx = (eidx + 1) % 4;
      end
    end
    chk(hold_err == 0, "R10 request held until ack", hold_err, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule